// File: doc/BRIEF.md
# Keyed configuration port with banked GPIO

This block is a configuration target that a host reaches through two byte-wide I/O locations: an index port and a data port. The host first writes a register number to the index port. It then reads or writes that register through the data port. The whole register space stays closed until the host writes an unlock byte to the index port twice in a row. A separate lock byte closes it again. While the space is closed, the data port has no effect on any register.

One register holds a logical-device number, and that number chooses which device registers are visible. Identification registers report a manufacturer code, a device code and a revision, and they can be read whatever device is selected. When the GPIO device is selected, a set of 8-bit GPIO banks appears. In each bank the host can set a direction, an output value and a drive mode for every pin, and it can read the synchronised pin levels. The pad controls that come out of the banks support both push-pull and open-drain signalling.

Top module: `kcfg_port`

## Requirements
- R1: `io_addr`=0 selects the index port and `io_addr`=1 selects the data port. Register access opens only after two consecutive index-port writes of 0x87. Once open, a further 0x87 keeps it open.
- R2: While the port is locked, data-port writes change no register and every read returns 0xFF. An index write other than 0x87 between the two keys restarts the unlock sequence.
- R3: An index-port write of 0xAA locks the port. Register contents are kept across a lock and a later unlock.
- R4: Index 0x20 returns DEV_ID[15:8], 0x21 returns DEV_ID[7:0], 0x22 returns REV, 0x23 returns 0x19 and 0x24 returns 0x34. These registers are read-only and readable with any logical device selected.
- R5: Index 0x07 is a read/write logical-device register. Bank registers are visible only when it holds 0x06. Otherwise they read 0x00 and ignore writes, while the pads keep their state.
- R6: Bank b sits at base index 0xF0 − 0x10·b. Offset +0 holds direction, +1 output data, +2 pin input and +3 drive mode. The direction, output-data and mode registers read back what was written.
- R7: Bit i of each bank register controls pin 8·b+i. When direction=1 and mode=1 (push-pull), `pad_oe`=1 and `pad_out` equals the output bit. When direction=1 and mode=0 (open-drain), `pad_oe` is 1 only when the output bit is 0, and `pad_out`=0. When direction=0, `pad_oe`=0.
- R8: The pin-input register returns `pad_in` through a two-flop synchroniser and ignores writes.
- R9: After reset, the port is locked, the index and logical-device registers are 0x00, all bank registers are 0x00 (inputs, open-drain) and `pad_oe` is all zero.
- R10: `io_rdata` updates on the clock edge that samples `io_rd` and holds otherwise. An open data-port read of an unmapped index returns 0x00, and an open index-port read returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_addr | input | 1 | 0 = index port, 1 = data port |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte |
| pad_in | input | NUM_BANKS*8 | Pad levels, asynchronous |
| pad_out | output | NUM_BANKS*8 | Pad output value |
| pad_oe | output | NUM_BANKS*8 | Pad output enable |

## Verification
The hardest condition to reach is an unlock sequence that is broken partway through. The stimulus writes one key, then an unrelated index byte, then the key again. It then confirms that the port still reads 0xFF, and that one more key opens it. A second hard case is bank access while the wrong logical device is selected. The stimulus writes a bank register under device 0x00, then selects the GPIO device and reads 0x00 back from that register. It later deselects the GPIO device and confirms that the pads keep driving.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;
  localparam int REG_W = 8;
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] LDN_GPIO  = 8'h06;
  localparam logic [7:0] IDX_DEVH  = 8'h20;
  localparam logic [7:0] IDX_DEVL  = 8'h21;
  localparam logic [7:0] IDX_REV   = 8'h22;
  localparam logic [7:0] IDX_MANH  = 8'h23;
  localparam logic [7:0] IDX_MANL  = 8'h24;
  localparam logic [7:0] RD_LOCKED = 8'hFF;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } lock_st_e;
endpackage

// File: rtl/kcfg_unlock.sv
module kcfg_unlock
  import kcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_wr,
  input  logic [REG_W-1:0] wdata,
  output logic             open
);
  lock_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_LOCKED;
    end else if (idx_wr) begin
      if (wdata == KEY_CLOSE)
        st_q <= ST_LOCKED;
      else if (wdata == KEY_OPEN)
        st_q <= (st_q == ST_LOCKED) ? ST_HALF : ST_OPEN;
      else if (st_q != ST_OPEN)
        st_q <= ST_LOCKED;
    end
  end

  assign open = (st_q == ST_OPEN);
endmodule

// File: rtl/kcfg_gpio_bank.sv
module kcfg_gpio_bank
  import kcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       off,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] pad_in,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] pad_out,
  output logic [REG_W-1:0] pad_oe,
  output logic [REG_W-1:0] dir_o,
  output logic [REG_W-1:0] mode_o
);
  logic [REG_W-1:0] dir_q, out_q, mode_q, sync1_q, sync2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      out_q   <= '0;
      mode_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (wr) begin
        case (off)
          2'd0:    dir_q  <= wdata;
          2'd1:    out_q  <= wdata;
          2'd3:    mode_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (off)
      2'd0:    rdata = dir_q;
      2'd1:    rdata = out_q;
      2'd2:    rdata = sync2_q;
      default: rdata = mode_q;
    endcase
  end

  // push-pull: enable follows direction; open-drain: sink only on a 0
  assign pad_oe  = dir_q & (mode_q | ~out_q);
  assign pad_out = out_q & mode_q;
  assign dir_o   = dir_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/kcfg_port.sv
module kcfg_port
  import kcfg_pkg::*;
#(
  parameter int          NUM_BANKS = 4,
  parameter logic [15:0] DEV_ID    = 16'h7A31,
  parameter logic [7:0]  REV       = 8'h05,
  parameter logic [15:0] MAN_ID    = 16'h1934
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic                   io_addr,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  input  logic [NUM_BANKS*8-1:0] pad_in,
  output logic [NUM_BANKS*8-1:0] pad_out,
  output logic [NUM_BANKS*8-1:0] pad_oe
);
  localparam int NPINS = NUM_BANKS * REG_W;

  logic             cfg_open;
  logic [REG_W-1:0] idx_q, ldn_q, rd_val;
  logic             data_wr, gpio_sel;
  logic [NUM_BANKS-1:0] hit;
  logic [REG_W-1:0] bank_rd [NUM_BANKS];
  logic [NPINS-1:0] dir_vec, mode_vec;

  kcfg_unlock u_unlock (
    .clk    (clk),
    .rst    (rst),
    .idx_wr (io_wr && !io_addr),
    .wdata  (io_wdata),
    .open   (cfg_open)
  );

  assign data_wr  = io_wr && io_addr && cfg_open;
  assign gpio_sel = (ldn_q == LDN_GPIO);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (io_wr && !io_addr && cfg_open)
        idx_q <= io_wdata;
      if (data_wr && idx_q == IDX_LDN)
        ldn_q <= io_wdata;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [3:0] HI = 4'(15 - b);
    assign hit[b] = gpio_sel && (idx_q[7:4] == HI) && (idx_q[3:2] == 2'b00);

    kcfg_gpio_bank u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr      (data_wr && hit[b]),
      .off     (idx_q[1:0]),
      .wdata   (io_wdata),
      .pad_in  (pad_in[b*REG_W +: REG_W]),
      .rdata   (bank_rd[b]),
      .pad_out (pad_out[b*REG_W +: REG_W]),
      .pad_oe  (pad_oe[b*REG_W +: REG_W]),
      .dir_o   (dir_vec[b*REG_W +: REG_W]),
      .mode_o  (mode_vec[b*REG_W +: REG_W])
    );
  end

  always_comb begin
    rd_val = '0;
    if (!cfg_open) begin
      rd_val = RD_LOCKED;
    end else if (!io_addr) begin
      rd_val = idx_q;
    end else begin
      case (idx_q)
        IDX_LDN:  rd_val = ldn_q;
        IDX_DEVH: rd_val = DEV_ID[15:8];
        IDX_DEVL: rd_val = DEV_ID[7:0];
        IDX_REV:  rd_val = REV;
        IDX_MANH: rd_val = MAN_ID[15:8];
        IDX_MANL: rd_val = MAN_ID[7:0];
        default: begin
          for (int b = 0; b < NUM_BANKS; b++)
            if (hit[b]) rd_val = bank_rd[b];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_val;
  end
endmodule

// File: rtl/kcfg_port_chk.sv
module kcfg_port_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             io_wr,
  input logic             io_rd,
  input logic             io_addr,
  input logic [7:0]       io_wdata,
  input logic [7:0]       io_rdata,
  input logic             cfg_open,
  input logic [7:0]       ldn_q,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] dir_vec,
  input logic [NPINS-1:0] mode_vec
);
  a_r1_open_after_key: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(io_wr && !io_addr && io_wdata == 8'h87));

  a_r2_locked_reads_ff: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !cfg_open) |=> (io_rdata == 8'hFF));

  a_r2_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr && !cfg_open) |=> $stable(ldn_q));

  a_r3_close_key: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !io_addr && io_wdata == 8'hAA) |=> !cfg_open);

  a_r7_od_never_high: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_out & ~mode_vec) == '0);

  a_r7_oe_needs_dir: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~dir_vec) == '0);
endmodule

bind kcfg_port kcfg_port_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_wr    (io_wr),
  .io_rd    (io_rd),
  .io_addr  (io_addr),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .cfg_open (cfg_open),
  .ldn_q    (ldn_q),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .dir_vec  (dir_vec),
  .mode_vec (mode_vec)
);

// File: tb/kcfg_port_tb.sv
module kcfg_port_tb;
  localparam int NB = 4;
  localparam int NP = NB * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          io_wr = 1'b0, io_rd = 1'b0, io_addr = 1'b0;
  logic [7:0]    io_wdata = '0;
  logic [7:0]    io_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;

  always #10ns clk = ~clk;

  kcfg_port #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  logic rd_q = 1'b0;

  always @(posedge clk) rd_q <= io_rd;

  // monitor: compare each read result against the scoreboard
  always @(negedge clk) begin
    if (rd_q) begin
      exp_t e;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL unexpected read: actual %02h expected none", io_rdata);
      end else begin
        e = exp_q.pop_front();
        if (io_rdata !== e.val) begin
          n_err++;
          $display("FAIL %s: actual %02h expected %02h", e.tag, io_rdata, e.val);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    io_wr = 1'b1; io_addr = a; io_wdata = v;
    cyc();
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] ev, input string tag);
    exp_t e;
    e.val = ev; e.tag = tag;
    exp_q.push_back(e);
    io_rd = 1'b1; io_addr = a;
    cyc();
    io_rd = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] idx, input logic [7:0] ev, input string tag);
    wr(1'b0, idx);
    rd(1'b1, ev, tag);
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] v);
    wr(1'b0, idx);
    wr(1'b1, v);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] ex, input string tag);
    n_chk++;
    if (act !== ex) begin
      n_err++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, ex);
    end
  endtask

  function automatic logic [7:0] bbase(input int b);
    return 8'(8'hF0 - 8'h10 * b);
  endfunction

  initial begin
    #(20ns * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk(pad_oe, '0, "R9 oe after reset");
    rd(1'b1, 8'hFF, "R2 locked read");
    // locked writes must not land
    wr_reg(8'h07, 8'h06);
    // broken key sequence
    wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
    rd(1'b1, 8'hFF, "R2 interrupted key stays locked");
    wr(1'b0, 8'h87);
    rd_reg(8'h07, 8'h00, "R1 R2 R9 ldn after unlock, locked write ignored");
    wr(1'b0, 8'h87);
    rd(1'b0, 8'h87, "R1 second key keeps open, index readback R10");
    rd_reg(8'h20, 8'h7A, "R4 dev hi");
    rd_reg(8'h21, 8'h31, "R4 dev lo");
    rd_reg(8'h22, 8'h05, "R4 rev");
    rd_reg(8'h23, 8'h19, "R4 man hi");
    rd_reg(8'h24, 8'h34, "R4 man lo");
    rd_reg(8'h30, 8'h00, "R10 unmapped");
    // bank write with wrong device selected
    wr_reg(bbase(0), 8'hFF);
    wr_reg(8'h07, 8'h06);
    rd_reg(8'h07, 8'h06, "R5 ldn readback");
    rd_reg(bbase(0), 8'h00, "R5 write ignored under other ldn");
    wr_reg(bbase(0),     8'h0F);
    wr_reg(bbase(0) + 1, 8'h05);
    wr_reg(bbase(0) + 3, 8'h03);
    rd_reg(bbase(0),     8'h0F, "R6 dir readback");
    rd_reg(bbase(0) + 1, 8'h05, "R6 out readback");
    rd_reg(bbase(0) + 3, 8'h03, "R6 mode readback");
    chk({24'h0, pad_oe[7:0]},  32'h0B, "R7 bank0 oe");
    chk({24'h0, pad_out[7:0]}, 32'h01, "R7 bank0 out");
    wr_reg(bbase(3),     8'hFF);
    wr_reg(bbase(3) + 1, 8'hA5);
    wr_reg(bbase(3) + 3, 8'hFF);
    chk({24'h0, pad_oe[31:24]},  32'hFF, "R7 bank3 push-pull oe");
    chk({24'h0, pad_out[31:24]}, 32'hA5, "R7 bank3 push-pull out");
    rd_reg(bbase(3) + 1, 8'hA5, "R6 bank3 base");
    pad_in = 32'h3C00_5A96;
    repeat (3) cyc();
    rd_reg(bbase(0) + 2, 8'h96, "R8 bank0 input");
    wr_reg(bbase(1) + 2, 8'hFF);
    rd_reg(bbase(1) + 2, 8'h5A, "R8 input ignores write");
    rd_reg(bbase(3) + 2, 8'h3C, "R8 bank3 input");
    wr(1'b0, 8'hAA);
    rd(1'b1, 8'hFF, "R3 relock");
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    rd_reg(bbase(0) + 1, 8'h05, "R3 contents kept");
    wr_reg(8'h07, 8'h01);
    rd_reg(bbase(0), 8'h00, "R5 bank hidden");
    chk({24'h0, pad_oe[7:0]}, 32'h0B, "R5 pads keep state");
    repeat (3) cyc();
    chk(exp_q.size(), 0, "R10 all reads returned");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule